// File: doc/BRIEF.md
# Prefixed Bit-Operation Sequencer

This block is a small multi-cycle controller that carries out one instruction from the prefixed bit-manipulation group of an 8-bit processor core. On a start pulse it fetches the bytes that follow the prefix from a synchronous memory port. It then selects the operand, which is either one of eight register codes or the memory byte at a computed address. It runs the operand through a combinational rotate/shift/bit unit and writes the result and the flags back. When it finishes it reports the advanced program counter and the number of T-states the instruction consumed.

Two addressing forms exist. In the plain form the byte at the program counter is the opcode, and code 6 in its low field selects the memory byte addressed by HL. In the indexed form the byte at the program counter is a signed displacement and the opcode follows it. The operand is then always the memory byte at the chosen index register plus the displacement. The low opcode field names a register that also receives a copy of the result. Memory and register file both answer a read one clock after the request.

Top module: `bitop_sequencer`

## Requirements
- R1: In the plain form (idx_mode 00) the sequencer reads the opcode at pc_in. When the opcode's bits [2:0] are 6 it reads the operand at hl. pc_out ends at pc_in+1, and refresh_inc pulses exactly once.
- R2: In the indexed form (idx_mode 01 selects ix, 1x selects iy) the sequencer reads a displacement at pc_in and the opcode at pc_in+1. The operand address is the index register plus the sign-extended displacement, modulo 2^16. pc_out ends at pc_in+2, and refresh_inc never pulses.
- R3: In the indexed form the operand is the memory byte, whatever value the opcode's bits [2:0] hold.
- R4: In the indexed form the result byte is also written to register opcode[2:0] in the same cycle as the rest of the write-back, unless that code is 6. For a bit test the result byte is the unchanged operand.
- R5: tstates at done equals a base plus an operand cost. The base is 4 for the plain form and 8 for the indexed form. The operand cost is 7 for a memory rotate/shift (opcode[7:6]=00), 4 for any other memory operation, and 0 for a register operand.
- R6: When opcode[7:6]=00, opcode[5:3] selects the operation. The codes, in order 0 to 7, are: rotate left circular, rotate right circular, rotate left through C, rotate right through C, shift left, arithmetic shift right, shift left inserting 1, and logical shift right. The flags are written in the layout S7 Z6 Y5 H4 X3 P2 N1 C0, with C the bit shifted out, S/Y/X copied from the result, Z set for a zero result, P set for even parity, and H and N cleared.
- R7: When opcode[7:6]=01 (bit test of bit opcode[5:3]), the flags become: C kept, H=1, Z=P=1 when the tested bit is 0, S=N=0, and Y/X from operand bits 5/3. Neither memory nor the operand register is written.
- R8: When opcode[7:6] is 10 (clear) or 11 (set), only bit opcode[5:3] of the operand changes, and the flags are not written.
- R9: A memory operand is read and then written back at the same address with the result. The write comes after the read, and a bit test issues no memory write.
- R10: After reset every strobe is low and busy is low. done pulses for exactly one cycle per instruction, with tstates and pc_out final in that cycle. A start while busy is ignored.
- R11: With a register operand in the plain form, register opcode[2:0] is read and the result is written back to it. No memory access follows the opcode fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one instruction (accepted when idle) |
| idx_mode | input | 2 | 00 plain, 01 index via ix, 1x index via iy |
| pc_in | input | 16 | Address of the first byte after the prefix |
| hl | input | 16 | Plain-form memory operand address |
| ix | input | 16 | First index base |
| iy | input | 16 | Second index base |
| flags_in | input | 8 | Current flag register |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe; data one cycle later |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| rf_raddr | output | 3 | Register-file read index; data one cycle later |
| rf_rdata | input | 8 | Register-file read data |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 3 | Register-file write index |
| rf_wdata | output | 8 | Register-file write data |
| flags_we | output | 1 | Flag register write strobe |
| flags_out | output | 8 | New flag value |
| refresh_inc | output | 1 | One-cycle pulse: bump the refresh counter |
| pc_out | output | 16 | Advanced program counter |
| tstates | output | 8 | T-states consumed by the instruction |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
In the indexed form, the write-back cycle may hold a memory write, a copy into a named register, a flag write and the done pulse together. The bench provokes this with indexed opcodes whose low field spans all eight codes, across every operation group. Each strobe is recorded separately, and its count, address and data are compared with a model of the requirements. A second start pulse during an instruction checks that the busy sequence is not disturbed: the bench expects the same read count and a single done.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int DATA_W = 8;
  localparam int REG_W  = 3;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_TEST  = 2'd1,
    GRP_CLR   = 2'd2,
    GRP_SET   = 2'd3
  } op_group_e;

  typedef enum logic [2:0] {
    S_IDLE, S_DREQ, S_DGET, S_OREQ, S_OGET, S_RREQ, S_RGET
  } seq_state_e;

  localparam logic [REG_W-1:0] MEM_CODE = 3'd6;
endpackage

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
(
  input  logic [4:0]        op_hi,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] flags_in,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] flags_out,
  output logic              wr_val,
  output logic              wr_flags
);
  logic [DATA_W-1:0] mask;
  logic [2:0]        sel;
  op_group_e         grp;
  logic              carry;
  logic              hit;

  assign sel = op_hi[2:0];
  assign grp = op_group_e'(op_hi[4:3]);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (sel == i[2:0]);
  end

  assign hit = |(opnd & mask);

  always_comb begin
    result    = opnd;
    flags_out = flags_in;
    carry     = 1'b0;
    wr_val    = 1'b1;
    wr_flags  = 1'b0;
    case (grp)
      GRP_SHIFT: begin
        wr_flags = 1'b1;
        case (sel)
          3'd0: begin carry = opnd[7]; result = {opnd[6:0], opnd[7]};     end
          3'd1: begin carry = opnd[0]; result = {opnd[0], opnd[7:1]};     end
          3'd2: begin carry = opnd[7]; result = {opnd[6:0], flags_in[0]}; end
          3'd3: begin carry = opnd[0]; result = {flags_in[0], opnd[7:1]}; end
          3'd4: begin carry = opnd[7]; result = {opnd[6:0], 1'b0};        end
          3'd5: begin carry = opnd[0]; result = {opnd[7], opnd[7:1]};     end
          3'd6: begin carry = opnd[7]; result = {opnd[6:0], 1'b1};        end
          default: begin carry = opnd[0]; result = {1'b0, opnd[7:1]};     end
        endcase
        flags_out = {result[7], (result == '0), result[5], 1'b0,
                     result[3], ~^result, 1'b0, carry};
      end
      GRP_TEST: begin
        wr_val    = 1'b0;
        wr_flags  = 1'b1;
        flags_out = {1'b0, ~hit, opnd[5], 1'b1, opnd[3], ~hit, 1'b0, flags_in[0]};
      end
      GRP_CLR: result = opnd & ~mask;
      default: result = opnd | mask;
    endcase
  end

  always_comb begin
    if (grp == GRP_TEST) begin
      assert_test_keeps_value_R7: assert (result == opnd && !wr_val);
    end
    if (grp == GRP_CLR || grp == GRP_SET) begin
      assert_single_bit_R8: assert ($countones(result ^ opnd) <= 1 && !wr_flags);
    end
  end
endmodule

// File: rtl/bitop_tacc.sv
module bitop_tacc #(
  parameter int T_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [T_W-1:0] load_val,
  input  logic           add,
  input  logic [T_W-1:0] add_val,
  output logic [T_W-1:0] total
);
  always_ff @(posedge clk) begin
    if (rst)       total <= '0;
    else if (load) total <= load_val;
    else if (add)  total <= total + add_val;
  end

  assert_tacc_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    add && !load |-> ({1'b0, total} + {1'b0, add_val}) <= {1'b0, {T_W{1'b1}}});
endmodule

// File: rtl/bitop_sequencer.sv
module bitop_sequencer
  import bitop_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int T_W         = 8,
  parameter int T_PLAIN     = 4,
  parameter int T_INDEX     = 8,
  parameter int T_MEM_SHIFT = 7,
  parameter int T_MEM_OTHER = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        idx_mode,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] hl,
  input  logic [ADDR_W-1:0] ix,
  input  logic [ADDR_W-1:0] iy,
  input  logic [DATA_W-1:0] flags_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [REG_W-1:0]  rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              flags_we,
  output logic [DATA_W-1:0] flags_out,
  output logic              refresh_inc,
  output logic [ADDR_W-1:0] pc_out,
  output logic [T_W-1:0]    tstates,
  output logic              busy,
  output logic              done
);
  localparam int DISP_EXT = ADDR_W - DATA_W;

  seq_state_e        state;
  logic              indexed;
  logic              memop;
  logic [ADDR_W-1:0] ea;
  logic [ADDR_W-1:0] pc_start;
  logic [DATA_W-1:0] opcode;
  logic [REG_W-1:0]  dst;
  logic              start_ok;
  logic              start_idx;
  logic              fetch_mem;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] alu_res;
  logic [DATA_W-1:0] alu_flags;
  logic              alu_wv;
  logic              alu_wf;
  logic              t_add;
  logic [T_W-1:0]    t_load_val;
  logic [T_W-1:0]    t_add_val;

  assign busy      = (state != S_IDLE);
  assign start_ok  = (state == S_IDLE) && start;
  assign start_idx = |idx_mode;
  assign fetch_mem = indexed || (mem_rdata[2:0] == MEM_CODE);
  assign operand   = memop ? mem_rdata : rf_rdata;

  assign t_load_val = start_idx ? T_W'(T_INDEX) : T_W'(T_PLAIN);
  assign t_add      = (state == S_OGET) && fetch_mem;
  assign t_add_val  = (mem_rdata[7:6] == 2'b00) ? T_W'(T_MEM_SHIFT) : T_W'(T_MEM_OTHER);

  bitop_alu u_alu (
    .op_hi    (opcode[7:3]),
    .opnd     (operand),
    .flags_in (flags_in),
    .result   (alu_res),
    .flags_out(alu_flags),
    .wr_val   (alu_wv),
    .wr_flags (alu_wf)
  );

  bitop_tacc #(.T_W(T_W)) u_tacc (
    .clk     (clk),
    .rst     (rst),
    .load    (start_ok),
    .load_val(t_load_val),
    .add     (t_add),
    .add_val (t_add_val),
    .total   (tstates)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      indexed     <= 1'b0;
      memop       <= 1'b0;
      ea          <= '0;
      pc_start    <= '0;
      opcode      <= '0;
      dst         <= '0;
      mem_addr    <= '0;
      mem_rd      <= 1'b0;
      mem_we      <= 1'b0;
      mem_wdata   <= '0;
      rf_raddr    <= '0;
      rf_we       <= 1'b0;
      rf_waddr    <= '0;
      rf_wdata    <= '0;
      flags_we    <= 1'b0;
      flags_out   <= '0;
      refresh_inc <= 1'b0;
      pc_out      <= '0;
      done        <= 1'b0;
    end else begin
      mem_rd      <= 1'b0;
      mem_we      <= 1'b0;
      rf_we       <= 1'b0;
      flags_we    <= 1'b0;
      refresh_inc <= 1'b0;
      done        <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          indexed     <= start_idx;
          ea          <= (idx_mode == 2'b00) ? hl : (idx_mode == 2'b01) ? ix : iy;
          pc_start    <= pc_in;
          mem_rd      <= 1'b1;
          mem_addr    <= pc_in;
          pc_out      <= pc_in + 1'b1;
          refresh_inc <= !start_idx;
          state       <= start_idx ? S_DREQ : S_OREQ;
        end
        S_DREQ: state <= S_DGET;
        S_DGET: begin
          ea       <= ea + {{DISP_EXT{mem_rdata[7]}}, mem_rdata};
          mem_rd   <= 1'b1;
          mem_addr <= pc_out;
          pc_out   <= pc_out + 1'b1;
          state    <= S_OREQ;
        end
        S_OREQ: state <= S_OGET;
        S_OGET: begin
          opcode <= mem_rdata;
          dst    <= mem_rdata[2:0];
          memop  <= fetch_mem;
          if (fetch_mem) begin
            mem_rd   <= 1'b1;
            mem_addr <= ea;
          end else begin
            rf_raddr <= mem_rdata[2:0];
          end
          state <= S_RREQ;
        end
        S_RREQ: state <= S_RGET;
        default: begin
          flags_we  <= alu_wf;
          flags_out <= alu_flags;
          if (memop && alu_wv) begin
            mem_we    <= 1'b1;
            mem_addr  <= ea;
            mem_wdata <= alu_res;
          end
          if ((!memop && alu_wv) || (indexed && dst != MEM_CODE)) begin
            rf_we    <= 1'b1;
            rf_waddr <= dst;
            rf_wdata <= alu_res;
          end
          done  <= 1'b1;
          state <= S_IDLE;
        end
      endcase
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_refresh_plain_R1: assert property (@(posedge clk) disable iff (rst)
    refresh_inc |-> (state == S_OREQ) && !indexed);
  assert_copy_skip6_R4: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> rf_waddr != MEM_CODE);
  assert_rmw_order_R9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> memop && !mem_rd && done);
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> pc_out == pc_start + (indexed ? ADDR_W'(2) : ADDR_W'(1)));
  assert_tcost_set_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (tstates == T_W'(T_PLAIN)) ||
             (tstates == T_W'(T_PLAIN + T_MEM_SHIFT)) ||
             (tstates == T_W'(T_PLAIN + T_MEM_OTHER)) ||
             (tstates == T_W'(T_INDEX + T_MEM_SHIFT)) ||
             (tstates == T_W'(T_INDEX + T_MEM_OTHER)));
endmodule

// File: tb/sim_bitop_sequencer.sv
module sim_bitop_sequencer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        start = 1'b0;
  logic [1:0]  idx_mode = 2'b00;
  logic [15:0] pc_in = '0, hl = '0, ix = '0, iy = '0;
  logic [7:0]  flags_in = '0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [2:0]  rf_raddr;
  logic [7:0]  rf_rdata = '0;
  logic        rf_we;
  logic [2:0]  rf_waddr;
  logic [7:0]  rf_wdata;
  logic        flags_we;
  logic [7:0]  flags_out;
  logic        refresh_inc;
  logic [15:0] pc_out;
  logic [7:0]  tstates;
  logic        busy, done;

  bitop_sequencer u0 (
    .clk(clk), .rst(rst), .start(start), .idx_mode(idx_mode), .pc_in(pc_in),
    .hl(hl), .ix(ix), .iy(iy), .flags_in(flags_in),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .flags_we(flags_we), .flags_out(flags_out), .refresh_inc(refresh_inc),
    .pc_out(pc_out), .tstates(tstates), .busy(busy), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [7:0]  byte0, byte1, mem_opnd;
  logic [15:0] pc0, ea_exp;
  logic [7:0]  rf [8];

  always @(posedge clk) begin
    if (mem_rd)
      mem_rdata <= (mem_addr == pc0) ? byte0 :
                   (mem_addr == pc0 + 16'd1) ? byte1 :
                   (mem_addr == ea_exp) ? mem_opnd : 8'hEE;
    rf_rdata <= rf[rf_raddr];
  end

  int rd_cnt = 0, wr_cnt = 0, rfw_cnt = 0, fw_cnt = 0, ref_cnt = 0, done_cnt = 0;
  logic [15:0] rd_log [8];
  logic [15:0] wr_addr;
  logic [7:0]  wr_data, rfw_data, fw_data;
  logic [2:0]  rfw_addr;

  always @(negedge clk) begin
    if (mem_rd) begin rd_log[rd_cnt % 8] <= mem_addr; rd_cnt <= rd_cnt + 1; end
    if (mem_we) begin wr_addr <= mem_addr; wr_data <= mem_wdata; wr_cnt <= wr_cnt + 1; end
    if (rf_we)  begin rfw_addr <= rf_waddr; rfw_data <= rf_wdata; rfw_cnt <= rfw_cnt + 1; end
    if (flags_we) begin fw_data <= flags_out; fw_cnt <= fw_cnt + 1; end
    if (refresh_inc) ref_cnt <= ref_cnt + 1;
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] model(input logic [7:0] op, input logic [7:0] x, input logic [7:0] f);
    logic [7:0] r;
    logic [7:0] fl;
    logic c, wv;
    int n;
    n = int'(op[5:3]);
    r = x; fl = f; c = 1'b0; wv = 1'b1;
    if (op[7:6] == 2'b00) begin
      case (op[5:3])
        3'd0: begin r = (x << 1) | (x >> 7); c = x[7]; end
        3'd1: begin r = (x >> 1) | (x << 7); c = x[0]; end
        3'd2: begin r = (x << 1) | {7'd0, f[0]}; c = x[7]; end
        3'd3: begin r = (x >> 1) | {f[0], 7'd0}; c = x[0]; end
        3'd4: begin r = x << 1; c = x[7]; end
        3'd5: begin r = (x >> 1) | (x & 8'h80); c = x[0]; end
        3'd6: begin r = (x << 1) | 8'h01; c = x[7]; end
        default: begin r = x >> 1; c = x[0]; end
      endcase
      fl = {7'd0, c} | (r & 8'hA8) | ((r == 8'h00) ? 8'h40 : 8'h00) | ((^r) ? 8'h00 : 8'h04);
    end else if (op[7:6] == 2'b01) begin
      wv = 1'b0;
      fl = (f & 8'h01) | (x[n] ? 8'h10 : 8'h54) | (x & 8'h28);
    end else if (op[7:6] == 2'b10) r = x & ~(8'h01 << n);
    else r = x | (8'h01 << n);
    return {wv, fl, r};
  endfunction

  task automatic run(input logic [1:0] mode, input logic [7:0] op, input logic [7:0] d,
                     input logic [7:0] x, input logic [7:0] fin, input logic [15:0] pc,
                     input logic [15:0] hl_v, input logic [15:0] ix_v, input logic [15:0] iy_v,
                     input bit poke);
    bit idx, memop, wflags, expect_rf;
    logic [16:0] m;
    logic [7:0] opnd_v, res, fl;
    logic [2:0] fld;
    int t_exp, rd0, wr0, rfw0, fw0, ref0, done0, waited;
    logic [7:0] t_at_done;
    logic [15:0] pc_at_done;
    string rtag, gtag;
    idx   = (mode != 2'b00);
    fld   = op[2:0];
    memop = idx || (fld == 3'd6);
    @(negedge clk);
    pc0 = pc;
    byte0 = idx ? d : op;
    byte1 = op;
    mem_opnd = x;
    ea_exp = (mode == 2'b00) ? hl_v : (mode == 2'b01) ? ix_v + {{8{d[7]}}, d} : iy_v + {{8{d[7]}}, d};
    opnd_v = memop ? x : rf[fld];
    m = model(op, opnd_v, fin);
    res = m[7:0]; fl = m[15:8];
    wflags = (op[7:6] <= 2'b01);
    t_exp = (idx ? 8 : 4) + (memop ? ((op[7:6] == 2'b00) ? 7 : 4) : 0);
    expect_rf = (!memop && m[16]) || (idx && fld != 3'd6);
    rtag = idx ? "R2" : "R1";
    gtag = (op[7:6] == 2'b00) ? "R6" : (op[7:6] == 2'b01) ? "R7" : "R8";
    rd0 = rd_cnt; wr0 = wr_cnt; rfw0 = rfw_cnt; fw0 = fw_cnt; ref0 = ref_cnt; done0 = done_cnt;
    idx_mode = mode; pc_in = pc; hl = hl_v; ix = ix_v; iy = iy_v; flags_in = fin;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 40) begin
      if (poke && waited == 1) begin start = 1'b1; idx_mode = ~mode; end
      else start = 1'b0;
      @(negedge clk);
      waited++;
    end
    start = 1'b0;
    chk(done == 1'b1, "R10 done seen", 32'(done), 32'd1);
    t_at_done = tstates; pc_at_done = pc_out;
    @(negedge clk);
    @(negedge clk);
    chk(done_cnt - done0 == 1 && !busy, "R10 single done", 32'(done_cnt - done0), 32'd1);
    chk(t_at_done == 8'(t_exp), "R5 tstates", 32'(t_at_done), 32'(t_exp));
    chk(pc_at_done == pc + (idx ? 16'd2 : 16'd1), {rtag, " pc_out"}, 32'(pc_at_done), 32'(pc + (idx ? 16'd2 : 16'd1)));
    chk(ref_cnt - ref0 == (idx ? 0 : 1), {rtag, " refresh"}, 32'(ref_cnt - ref0), idx ? 32'd0 : 32'd1);
    chk(rd_cnt - rd0 == (idx ? 3 : (memop ? 2 : 1)), poke ? "R10 busy start" : {rtag, " reads"},
        32'(rd_cnt - rd0), idx ? 32'd3 : (memop ? 32'd2 : 32'd1));
    chk(rd_log[rd0 % 8] == pc, {rtag, " first fetch"}, 32'(rd_log[rd0 % 8]), 32'(pc));
    if (idx) chk(rd_log[(rd0 + 1) % 8] == pc + 16'd1, "R2 opcode fetch", 32'(rd_log[(rd0 + 1) % 8]), 32'(pc + 16'd1));
    if (memop) chk(rd_log[(rd_cnt - 1) % 8] == ea_exp, idx ? "R3 operand addr" : "R1 operand addr",
                   32'(rd_log[(rd_cnt - 1) % 8]), 32'(ea_exp));
    chk(wr_cnt - wr0 == ((memop && m[16]) ? 1 : 0), "R9 write count", 32'(wr_cnt - wr0), (memop && m[16]) ? 32'd1 : 32'd0);
    if (memop && m[16]) chk(wr_addr == ea_exp && wr_data == res, "R9 write-back", {8'd0, wr_addr, wr_data}, {8'd0, ea_exp, res});
    chk(rfw_cnt - rfw0 == (expect_rf ? 1 : 0), idx ? "R4 copy count" : "R11 reg write count",
        32'(rfw_cnt - rfw0), expect_rf ? 32'd1 : 32'd0);
    if (expect_rf) chk(rfw_addr == fld && rfw_data == res, idx ? "R4 copy data" : "R11 reg data",
                       {21'd0, rfw_addr, rfw_data}, {21'd0, fld, res});
    chk(fw_cnt - fw0 == (wflags ? 1 : 0), {gtag, " flag write"}, 32'(fw_cnt - fw0), wflags ? 32'd1 : 32'd0);
    if (wflags) chk(fw_data == fl, {gtag, " flags"}, 32'(fw_data), 32'(fl));
    if (!idx && !memop && m[16]) chk(rfw_data == res, {gtag, " result"}, 32'(rfw_data), 32'(res));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) rf[i] = 8'(i * 37 + 5);
    pc0 = 16'h0100; ea_exp = 16'h8000; byte0 = '0; byte1 = '0; mem_opnd = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_we && !rf_we && !flags_we && !refresh_inc,
        "R10 reset state", {26'd0, busy, done, mem_rd, mem_we, rf_we, flags_we}, 32'd0);
    rst = 1'b0;
    // R11 rotate left circular of register 0 (plain)
    run(2'b00, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0120, 16'h9000, 16'hA000, 16'hB000, 1'b0);
    // R1 R9 logical shift right of memory through hl
    run(2'b00, 8'h3E, 8'h00, 8'h01, 8'h00, 16'h0130, 16'h9123, 16'hA000, 16'hB000, 1'b0);
    // R7 bit test of memory: no write
    run(2'b00, 8'h7E, 8'h00, 8'h7F, 8'h01, 16'h0140, 16'h9200, 16'hA000, 16'hB000, 1'b0);
    // R2 R3 R4 indexed, field 6: no register copy, negative displacement
    run(2'b01, 8'hC6, 8'h80, 8'h00, 8'h00, 16'h0150, 16'h9000, 16'hA000, 16'hB000, 1'b0);
    // R4 indexed bit test copies unchanged byte into register 7
    run(2'b10, 8'h4F, 8'h05, 8'h28, 8'hFF, 16'h0160, 16'h9000, 16'hA000, 16'hB000, 1'b0);
    // R2 address wrap past the top of memory
    run(2'b01, 8'h96, 8'h20, 8'hFF, 8'h00, 16'h0170, 16'h9000, 16'hFFF0, 16'hB000, 1'b0);
    // R10 start pulse while busy is ignored
    run(2'b01, 8'h16, 8'hFE, 8'h80, 8'h01, 16'h0180, 16'h9000, 16'hA000, 16'hB000, 1'b1);
    run(2'b00, 8'hCB, 8'h00, 8'h00, 8'h00, 16'h0190, 16'h9000, 16'hA000, 16'hB000, 1'b1);
    for (int k = 0; k < 300; k++) begin
      for (int i = 0; i < 8; i++) rf[i] = 8'($urandom);
      run(2'($urandom_range(0, 2)), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
          16'h0100 + 16'($urandom_range(0, 16'h01FF)), 16'h8000 | 16'($urandom),
          16'h8000 | 16'($urandom), 16'h8000 | 16'($urandom), ($urandom_range(0, 9) == 0));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule